// File: doc/BRIEF.md
# Parameter Block Fetch and Validate Unit

This unit starts a diskette command. A start pulse latches a 16-bit pointer. The unit then reads a seven-byte command block from system memory, one byte per access, over a request/valid read port. The block holds, in memory order:

- a channel word
- an instruction byte (opcode in bits 2:0, drive unit in bits 5:4)
- a record count
- a track number
- a sector number
- a buffer address, low byte first

Once the last byte arrives, the unit checks the command against three per-drive inputs:

- readiness
- density
- write protection

It then resolves the command in one of two ways. Commands that touch only head position finish inside the unit. Commands that move sector data (read, write, format) are handed to an external transfer engine through a one-cycle start pulse, and finish when that engine reports done.

Each completed command leaves a result type, an error byte and an interrupt flag. The result type is 2'b10 for success and 2'b00 for an error. A head position is kept for each drive. Seek and recalibrate update it, and it can be read back through a unit-select port.

Top module: `pbv_top`

## Requirements
- R1: After reset the unit is idle (busy low, mem_req low). res_type is 2'b10, res_err is 0 and irq is 0. Every drive position reads track 0, sector 1.
- R2: After start, exactly seven reads are made, at pointer+0 through pointer+6 in order. Each request holds its address until mem_valid is sampled with it. A start pulse that arrives while busy is ignored.
- R3: If the selected unit's ready input is low, the result is type 2'b00 with error byte 8'h80. This check takes precedence over every other check.
- R4: The address error applies to every opcode except recalibrate (3). It gives type 2'b00 with byte 8'h08 when any of these holds:
  - the sector is 0
  - the sector exceeds the last sector
  - sector plus count exceeds the last sector plus one
  - the track exceeds 76
- R5: The last sector depends on density. It is 52 when the unit's drv_dbl bit is 1 and 26 when that bit is 0.
- R6: Recalibrate (3) succeeds with any sector and track value. It sets the unit's track to 0 and its sector to the supplied sector.
- R7: Seek (1) succeeds and stores the supplied track and sector as the unit's position. Nop (0), verify (5) and write-deleted (7) succeed without a transfer pulse and without changing any position.
- R8: Format (2) and write (6) on a unit whose drv_wprot bit is 1 give type 2'b00 with byte 8'h20, and no transfer pulse. Read (4) is not affected by write protection.
- R9: A legal read, format or write raises xfer_start for exactly one cycle. That cycle carries the channel word, the instruction byte, the count, the track, the sector, and the buffer address {byte6, byte5}. The unit stays busy until xfer_done, then reports success.
- R10: Every completion sets irq, unless channel-word bits 5:4 equal 2'b01. irq_clr clears irq. A completion in the same cycle as irq_clr wins.
- R11: A successful result leaves res_err at 0. An error result has exactly one bit set in res_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command; sampled while idle |
| pb_ptr | input | 16 | Command block pointer, latched on start |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory read data |
| mem_valid | input | 1 | Read data valid; completes the current request |
| drv_ready | input | 4 | Per-unit ready |
| drv_dbl | input | 4 | Per-unit double density (1) or single (0) |
| drv_wprot | input | 4 | Per-unit write protect |
| xfer_start | output | 1 | One-cycle transfer hand-off pulse |
| xfer_chan | output | 8 | Channel word for the transfer |
| xfer_instr | output | 8 | Instruction byte for the transfer |
| xfer_count | output | 8 | Record count |
| xfer_track | output | 8 | Track |
| xfer_sector | output | 8 | First sector |
| xfer_buf | output | 16 | Buffer address |
| xfer_done | input | 1 | Transfer engine finished |
| res_type | output | 2 | Result type: 2'b10 success, 2'b00 error |
| res_err | output | 8 | Error byte (8'h80, 8'h08 or 8'h20) |
| irq | output | 1 | Completion interrupt flag |
| irq_clr | input | 1 | Clear the interrupt flag |
| pos_sel | input | 2 | Unit whose position is shown |
| pos_track | output | 8 | Selected unit's track |
| pos_sector | output | 8 | Selected unit's sector |

## Verification
The hardest cases to reach are the exact edges of the sector window. A single-density and a double-density drive need different limits, and the sum check must be hit exactly at last+1 and one past it. The bench writes command blocks into its own memory model and sets the density straps per unit. It then sends the same sector/count pairs to a single-density unit and a double-density unit, so each limit is crossed from both sides. A second start pulse is also raised in the middle of a fetch, and the bench checks that the logged read addresses are unchanged.

// File: rtl/pbv_pkg.sv
package pbv_pkg;

    localparam int PB_BYTES    = 7;
    localparam int TRACK_LAST  = 76;
    localparam int SEC_LAST_DD = 52;
    localparam int SEC_LAST_SD = 26;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_SEEK   = 3'd1,
        OP_FMT    = 3'd2,
        OP_RECAL  = 3'd3,
        OP_READ   = 3'd4,
        OP_VERIFY = 3'd5,
        OP_WRITE  = 3'd6,
        OP_WDEL   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        RT_ERR = 2'b00,
        RT_OK  = 2'b10
    } rtype_e;

    localparam logic [7:0] EB_NOTRDY = 8'h80;
    localparam logic [7:0] EB_WPROT  = 8'h20;
    localparam logic [7:0] EB_ADDR   = 8'h08;

    typedef struct packed {
        logic [7:0]  chan;
        logic [7:0]  instr;
        logic [7:0]  count;
        logic [7:0]  track;
        logic [7:0]  sector;
        logic [15:0] buf_addr;
    } pblk_t;

    typedef struct packed {
        logic       xfer;
        rtype_e     rtype;
        logic [7:0] err;
        logic       pos_wr;
        logic       pos_home;
    } verdict_t;

    function automatic op_e op_of(logic [7:0] instr);
        return op_e'(instr[2:0]);
    endfunction

    function automatic logic [1:0] unit_of(logic [7:0] instr);
        return instr[5:4];
    endfunction

    function automatic logic irq_masked(logic [7:0] chan);
        return chan[5:4] == 2'b01;
    endfunction

endpackage

// File: rtl/pbv_fetch.sv
module pbv_fetch
    import pbv_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NBYTES = PB_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_valid,
    output logic              done,
    output pblk_t             blk
);
    localparam int IDX_W = $clog2(NBYTES);

    logic             active;
    logic [IDX_W-1:0] idx;
    logic [7:0]       byt [NBYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                idx    <= '0;
            end else if (active && mem_valid) begin
                byt[idx] <= mem_rdata;
                if (idx == IDX_W'(NBYTES - 1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assign mem_req  = active;
    assign mem_addr = base + ADDR_W'(idx);

    assign blk.chan     = byt[0];
    assign blk.instr    = byt[1];
    assign blk.count    = byt[2];
    assign blk.track    = byt[3];
    assign blk.sector   = byt[4];
    assign blk.buf_addr = {byt[6], byt[5]};

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))) else $error("hold"); // R2

endmodule

// File: rtl/pbv_check.sv
module pbv_check
    import pbv_pkg::*;
#(
    parameter int UNITS = 4
) (
    input  op_e        op,
    input  logic [1:0] unit,
    input  logic [7:0] count,
    input  logic [7:0] track,
    input  logic [7:0] sector,
    input  logic [UNITS-1:0] drv_ready,
    input  logic [UNITS-1:0] drv_dbl,
    input  logic [UNITS-1:0] drv_wprot,
    output verdict_t   v
);
    logic [7:0] last_sec;
    logic [8:0] span;
    logic       bad_addr;

    always_comb begin
        last_sec = drv_dbl[unit] ? 8'(SEC_LAST_DD) : 8'(SEC_LAST_SD);
        span     = {1'b0, sector} + {1'b0, count};
        bad_addr = (op != OP_RECAL) &&
                   ((sector == 8'd0) || (sector > last_sec) ||
                    (span > ({1'b0, last_sec} + 9'd1)) ||
                    (track > 8'(TRACK_LAST)));

        v.xfer     = 1'b0;
        v.rtype    = RT_OK;
        v.err      = 8'h00;
        v.pos_wr   = 1'b0;
        v.pos_home = 1'b0;

        if (!drv_ready[unit]) begin
            v.rtype = RT_ERR;
            v.err   = EB_NOTRDY;
        end else if (bad_addr) begin
            v.rtype = RT_ERR;
            v.err   = EB_ADDR;
        end else if ((op == OP_FMT || op == OP_WRITE) && drv_wprot[unit]) begin
            v.rtype = RT_ERR;
            v.err   = EB_WPROT;
        end else begin
            case (op)
                OP_SEEK:                   v.pos_wr = 1'b1;
                OP_RECAL: begin
                    v.pos_wr   = 1'b1;
                    v.pos_home = 1'b1;
                end
                OP_FMT, OP_READ, OP_WRITE: v.xfer = 1'b1;
                default:                   ;
            endcase
        end
    end

endmodule

// File: rtl/pbv_pos.sv
module pbv_pos #(
    parameter int UNITS = 4,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic                     home,
    input  logic [$clog2(UNITS)-1:0] unit,
    input  logic [W-1:0]             track_in,
    input  logic [W-1:0]             sector_in,
    input  logic [$clog2(UNITS)-1:0] rd_unit,
    output logic [W-1:0]             rd_track,
    output logic [W-1:0]             rd_sector
);
    logic [W-1:0] trk [UNITS];
    logic [W-1:0] sec [UNITS];

    for (genvar g = 0; g < UNITS; g++) begin : g_unit
        always_ff @(posedge clk) begin
            if (rst) begin
                trk[g] <= '0;
                sec[g] <= W'(1);
            end else if (wr && unit == g) begin
                trk[g] <= home ? '0 : track_in;
                sec[g] <= sector_in;
            end
        end
    end

    assign rd_track  = trk[rd_unit];
    assign rd_sector = sec[rd_unit];

endmodule

// File: rtl/pbv_top.sv
module pbv_top
    import pbv_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int UNITS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] pb_ptr,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_valid,
    input  logic [UNITS-1:0]  drv_ready,
    input  logic [UNITS-1:0]  drv_dbl,
    input  logic [UNITS-1:0]  drv_wprot,
    output logic              xfer_start,
    output logic [7:0]        xfer_chan,
    output logic [7:0]        xfer_instr,
    output logic [7:0]        xfer_count,
    output logic [7:0]        xfer_track,
    output logic [7:0]        xfer_sector,
    output logic [ADDR_W-1:0] xfer_buf,
    input  logic              xfer_done,
    output logic [1:0]        res_type,
    output logic [7:0]        res_err,
    output logic              irq,
    input  logic              irq_clr,
    input  logic [1:0]        pos_sel,
    output logic [7:0]        pos_track,
    output logic [7:0]        pos_sector
);
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} state_e;

    state_e            state;
    logic [ADDR_W-1:0] base_q;
    rtype_e            rtype_q;
    logic              fetch_done;
    pblk_t             blk;
    verdict_t          vd;
    logic              go;

    assign go = (state == S_IDLE) && start;

    pbv_fetch #(.ADDR_W(ADDR_W), .NBYTES(PB_BYTES)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .base      (base_q),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_valid (mem_valid),
        .done      (fetch_done),
        .blk       (blk)
    );

    pbv_check #(.UNITS(UNITS)) u_check (
        .op        (op_of(blk.instr)),
        .unit      (unit_of(blk.instr)),
        .count     (blk.count),
        .track     (blk.track),
        .sector    (blk.sector),
        .drv_ready (drv_ready),
        .drv_dbl   (drv_dbl),
        .drv_wprot (drv_wprot),
        .v         (vd)
    );

    pbv_pos #(.UNITS(UNITS), .W(8)) u_pos (
        .clk       (clk),
        .rst       (rst),
        .wr        ((state == S_FETCH) && fetch_done && vd.pos_wr),
        .home      (vd.pos_home),
        .unit      (unit_of(blk.instr)),
        .track_in  (blk.track),
        .sector_in (blk.sector),
        .rd_unit   (pos_sel),
        .rd_track  (pos_track),
        .rd_sector (pos_sector)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            base_q      <= '0;
            rtype_q     <= RT_OK;
            res_err     <= 8'h00;
            irq         <= 1'b0;
            xfer_start  <= 1'b0;
            xfer_chan   <= '0;
            xfer_instr  <= '0;
            xfer_count  <= '0;
            xfer_track  <= '0;
            xfer_sector <= '0;
            xfer_buf    <= '0;
        end else begin
            xfer_start <= 1'b0;
            if (irq_clr) irq <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        base_q <= pb_ptr;
                        state  <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (fetch_done) begin
                        if (vd.xfer) begin
                            xfer_start  <= 1'b1;
                            xfer_chan   <= blk.chan;
                            xfer_instr  <= blk.instr;
                            xfer_count  <= blk.count;
                            xfer_track  <= blk.track;
                            xfer_sector <= blk.sector;
                            xfer_buf    <= ADDR_W'(blk.buf_addr);
                            state       <= S_XFER;
                        end else begin
                            rtype_q <= vd.rtype;
                            res_err <= vd.err;
                            if (!irq_masked(blk.chan)) irq <= 1'b1;
                            state   <= S_IDLE;
                        end
                    end
                end
                S_XFER: begin
                    if (xfer_done) begin
                        rtype_q <= RT_OK;
                        res_err <= 8'h00;
                        if (!irq_masked(blk.chan)) irq <= 1'b1;
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy     = (state != S_IDLE);
    assign res_type = rtype_q;

    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy) else $error("req idle"); // R2
    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (res_type == RT_ERR) |-> ($countones(res_err) == 1)) else $error("err"); // R11
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (res_type == RT_OK) |-> (res_err == 8'h00)) else $error("ok"); // R11
    AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start) else $error("pulse"); // R9
    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(busy)) else $error("irq"); // R10

endmodule

// File: tb/pbv_top_tb.sv
module pbv_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pb_ptr = '0;
    logic        busy, mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        mem_valid = 1'b0;
    logic [3:0]  drv_ready = 4'b1111, drv_dbl = 4'b1011, drv_wprot = 4'b0000;
    logic        xfer_start;
    logic [7:0]  xfer_chan, xfer_instr, xfer_count, xfer_track, xfer_sector;
    logic [15:0] xfer_buf;
    logic        xfer_done = 1'b0;
    logic [1:0]  res_type;
    logic [7:0]  res_err;
    logic        irq;
    logic        irq_clr = 1'b0;
    logic [1:0]  pos_sel = '0;
    logic [7:0]  pos_track, pos_sector;

    pbv_top u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    logic [7:0]  mem [256];
    logic [15:0] rd_log [16];
    int rd_n = 0, lat = 0, wcnt = 0;
    int xpulses = 0, xcnt = 0;
    logic [7:0]  cap_chan, cap_instr, cap_cnt, cap_trk, cap_sec;
    logic [15:0] cap_buf;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
        if (mem_valid) mem_valid = 1'b0;
        else if (mem_req) begin
            if (wcnt < lat) wcnt++;
            else begin
                wcnt = 0;
                mem_valid = 1'b1;
                mem_rdata = mem[mem_addr[7:0]];
                if (rd_n < 16) rd_log[rd_n] = mem_addr;
                rd_n++;
            end
        end
        xfer_done = 1'b0;
        if (xfer_start) begin
            xpulses++;
            cap_chan = xfer_chan; cap_instr = xfer_instr; cap_cnt = xfer_count;
            cap_trk = xfer_track; cap_sec = xfer_sector; cap_buf = xfer_buf;
            xcnt = 3;
        end else if (xcnt != 0) begin
            xcnt--;
            if (xcnt == 0) xfer_done = 1'b1;
        end
    end

    task automatic put_blk(input logic [7:0] b, input logic [7:0] cw, input logic [1:0] unit,
                           input logic [2:0] op, input logic [7:0] nr, input logic [7:0] ta,
                           input logic [7:0] sa, input logic [15:0] ba);
        mem[b]      = cw;
        mem[b + 8'd1] = {2'b00, unit, 1'b0, op};
        mem[b + 8'd2] = nr;
        mem[b + 8'd3] = ta;
        mem[b + 8'd4] = sa;
        mem[b + 8'd5] = ba[7:0];
        mem[b + 8'd6] = ba[15:8];
    endtask

    task automatic run(input logic [15:0] ptr);
        int n;
        rd_n = 0; xpulses = 0;
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0; start = 1'b1; pb_ptr = ptr;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        chk("run completes", 32'(n >= 2000), 0);
    endtask

    task automatic expect_res(input string req, input logic [1:0] t, input logic [7:0] e, input logic i);
        chk({req, " type"}, 32'(res_type), 32'(t));
        chk({req, " err"}, 32'(res_err), 32'(e));
        chk({req, " irq"}, 32'(irq), 32'(i));
    endtask

    task automatic expect_pos(input string req, input logic [1:0] u, input logic [7:0] t, input logic [7:0] s);
        pos_sel = u;
        #1;
        chk({req, " track"}, 32'(pos_track), 32'(t));
        chk({req, " sector"}, 32'(pos_sector), 32'(s));
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        expect_res("R1", 2'b10, 8'h00, 1'b0);
        for (int u = 0; u < 4; u++) expect_pos("R1 pos", 2'(u), 8'd0, 8'd1);
    endtask

    task automatic t_fetch();
        lat = 2;
        put_blk(8'h30, 8'h00, 2'd0, 3'd0, 8'd1, 8'd0, 8'd1, 16'h0);
        run(16'h1230);
        chk("R2 read count", 32'(rd_n), 7);
        for (int k = 0; k < 7; k++) chk("R2 read addr", 32'(rd_log[k]), 32'(16'h1230 + k));
        lat = 0;
    endtask

    task automatic t_busy_start();
        int n;
        put_blk(8'h30, 8'h00, 2'd0, 3'd0, 8'd1, 8'd0, 8'd1, 16'h0);
        rd_n = 0;
        @(negedge clk); start = 1'b1; pb_ptr = 16'h1230;
        @(negedge clk); start = 1'b0;
        @(negedge clk); @(negedge clk);
        start = 1'b1; pb_ptr = 16'h0080;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        chk("R2 start while busy reads", 32'(rd_n), 7);
        chk("R2 start while busy addr", 32'(rd_log[6]), 32'h1236);
        chk("R2 busy idle after", 32'(busy), 0);
    endtask

    task automatic t_seek_dd();
        put_blk(8'h40, 8'h00, 2'd1, 3'd1, 8'd1, 8'd40, 8'd52, 16'h0);
        run(16'h0040);
        expect_res("R7 seek dd edge", 2'b10, 8'h00, 1'b1);
        expect_pos("R7 seek pos", 2'd1, 8'd40, 8'd52);
    endtask

    task automatic t_addr_sd();
        put_blk(8'h50, 8'h00, 2'd2, 3'd5, 8'd1, 8'd0, 8'd27, 16'h0);
        run(16'h0050); expect_res("R5 sd sector 27", 2'b00, 8'h08, 1'b1);
        put_blk(8'h50, 8'h00, 2'd2, 3'd1, 8'd2, 8'd3, 8'd26, 16'h0);
        run(16'h0050); expect_res("R4 sd span", 2'b00, 8'h08, 1'b1);
        expect_pos("R4 no pos change", 2'd2, 8'd0, 8'd1);
        put_blk(8'h50, 8'h00, 2'd2, 3'd5, 8'd1, 8'd77, 8'd26, 16'h0);
        run(16'h0050); expect_res("R4 track 77", 2'b00, 8'h08, 1'b1);
        put_blk(8'h50, 8'h00, 2'd2, 3'd0, 8'd1, 8'd0, 8'd0, 16'h0);
        run(16'h0050); expect_res("R4 sector 0", 2'b00, 8'h08, 1'b1);
        put_blk(8'h50, 8'h00, 2'd2, 3'd1, 8'd1, 8'd76, 8'd26, 16'h0);
        run(16'h0050); expect_res("R5 sd edge ok", 2'b10, 8'h00, 1'b1);
        expect_pos("R7 sd seek pos", 2'd2, 8'd76, 8'd26);
    endtask

    task automatic t_addr_dd();
        put_blk(8'h60, 8'h00, 2'd0, 3'd5, 8'd26, 8'd0, 8'd27, 16'h0);
        run(16'h0060); expect_res("R5 dd sector 27 ok", 2'b10, 8'h00, 1'b1);
        put_blk(8'h60, 8'h00, 2'd0, 3'd5, 8'd27, 8'd0, 8'd27, 16'h0);
        run(16'h0060); expect_res("R4 dd span over", 2'b00, 8'h08, 1'b1);
        put_blk(8'h60, 8'h00, 2'd0, 3'd0, 8'd1, 8'd0, 8'd1, 16'h0);
        run(16'h0060); expect_res("R11 ok clears err", 2'b10, 8'h00, 1'b1);
    endtask

    task automatic t_recal();
        put_blk(8'h70, 8'h00, 2'd3, 3'd1, 8'd1, 8'd10, 8'd5, 16'h0);
        run(16'h0070); expect_pos("R7 seek u3", 2'd3, 8'd10, 8'd5);
        put_blk(8'h70, 8'h00, 2'd3, 3'd3, 8'd1, 8'd200, 8'd0, 16'h0);
        run(16'h0070); expect_res("R6 recal exempt", 2'b10, 8'h00, 1'b1);
        expect_pos("R6 recal pos", 2'd3, 8'd0, 8'd0);
    endtask

    task automatic t_notready();
        drv_ready = 4'b1011;
        put_blk(8'h80, 8'h00, 2'd2, 3'd2, 8'd1, 8'd99, 8'd0, 16'h0);
        run(16'h0080); expect_res("R3 not ready", 2'b00, 8'h80, 1'b1);
        chk("R3 no transfer", 32'(xpulses), 0);
        drv_ready = 4'b1111;
    endtask

    task automatic t_wprot();
        drv_wprot = 4'b0010;
        put_blk(8'h90, 8'h00, 2'd1, 3'd2, 8'd1, 8'd1, 8'd1, 16'h0);
        run(16'h0090); expect_res("R8 format wp", 2'b00, 8'h20, 1'b1);
        chk("R8 format no xfer", 32'(xpulses), 0);
        put_blk(8'h90, 8'h00, 2'd1, 3'd6, 8'd1, 8'd1, 8'd1, 16'h0);
        run(16'h0090); expect_res("R8 write wp", 2'b00, 8'h20, 1'b1);
        put_blk(8'h90, 8'h00, 2'd1, 3'd4, 8'd2, 8'd1, 8'd1, 16'h2000);
        run(16'h0090); expect_res("R8 read on wp ok", 2'b10, 8'h00, 1'b1);
        chk("R8 read xfer", 32'(xpulses), 1);
        drv_wprot = 4'b0000;
    endtask

    task automatic t_xfer();
        put_blk(8'hA0, 8'h08, 2'd0, 3'd6, 8'd3, 8'd5, 8'd7, 16'hBEEF);
        run(16'h00A0);
        chk("R9 one pulse", 32'(xpulses), 1);
        chk("R9 chan", 32'(cap_chan), 32'h08);
        chk("R9 instr", 32'(cap_instr), 32'h06);
        chk("R9 count", 32'(cap_cnt), 3);
        chk("R9 track", 32'(cap_trk), 5);
        chk("R9 sector", 32'(cap_sec), 7);
        chk("R9 buf le", 32'(cap_buf), 32'hBEEF);
        expect_res("R9 done", 2'b10, 8'h00, 1'b1);
    endtask

    task automatic t_misc_ops();
        put_blk(8'hB0, 8'h00, 2'd0, 3'd7, 8'd1, 8'd2, 8'd1, 16'h0);
        run(16'h00B0); expect_res("R7 wdel ok", 2'b10, 8'h00, 1'b1);
        chk("R7 wdel no xfer", 32'(xpulses), 0);
        expect_pos("R7 wdel no pos", 2'd0, 8'd0, 8'd1);
        put_blk(8'hB0, 8'h10, 2'd0, 3'd0, 8'd1, 8'd0, 8'd1, 16'h0);
        run(16'h00B0); expect_res("R10 masked", 2'b10, 8'h00, 1'b0);
        put_blk(8'hB0, 8'h00, 2'd0, 3'd5, 8'd1, 8'd0, 8'd1, 16'h0);
        run(16'h00B0); expect_res("R10 set", 2'b10, 8'h00, 1'b1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk("R10 clear", 32'(irq), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fetch();
        t_busy_start();
        t_seek_dd();
        t_addr_sd();
        t_addr_dd();
        t_recal();
        t_notready();
        t_wprot();
        t_xfer();
        t_misc_ops();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule